// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Macrocell

This block is one output cell of a programmable sum-of-products logic device. It takes the product terms from an external AND array and combines them in an OR gate. A polarity bit can invert the result. Three configuration bits then decide how the cell behaves. It can drive the result through a clocked flip-flop, drive it straight to the pin, act as a bidirectional combinatorial pin, or give up its pin and act as an input. The pin is modelled as a data value (`pad_out`) and an enable (`pad_oe`). The cell also returns one feedback signal (`fb_out`) to the AND array.

The configuration is decoded into one of five named modes: `MC_REG`, `MC_COMB_OUT`, `MC_COMB_IO`, `MC_INPUT` and `MC_OFF` (every unused encoding). Mode transitions happen only when the configuration inputs change, and they take effect at once. The only stored state is the output flip-flop. It has three transitions:
- clear, on the asynchronous power-up reset;
- load, when the preload path is active on a clock edge;
- capture, on a clock edge in `MC_REG`.

In every other case it holds its value.

Top module: `pal_macrocell`

## Requirements
- R1: While `por_n` is low, the flip-flop is cleared asynchronously. In `MC_REG` this gives `pad_out`=0 and `fb_out`=1.
- R2: `MC_REG` is selected by `cfg_arch`=2'b01, `cfg_cell`=0. On each rising clock edge the flip-flop takes the OR of all eight terms (including `pt_in[7]`), passed through the polarity bit. `pad_out` shows the flip-flop and `fb_out` shows its inverse.
- R3: In `MC_REG`, `pad_oe` equals the inverse of `oe_pin_n` and does not depend on `pt_in[7]`.
- R4: `MC_COMB_OUT` is selected by `cfg_arch`=2'b10, `cfg_cell`=0. `pad_out` is the OR of all eight terms without any clock, `pad_oe`=1, and `fb_out`=0.
- R5: `MC_COMB_IO` is selected by `cfg_arch`=2'b01 or 2'b11 with `cfg_cell`=1. `pad_out` is the OR of `pt_in[6:0]` only.
- R6: In `MC_COMB_IO`, `pad_oe` equals `pt_in[7]` and `fb_out` equals `pin_in`.
- R7: `MC_INPUT` is selected by `cfg_arch`=2'b10, `cfg_cell`=1. It gives `pad_oe`=0, `pad_out`=0, and `fb_out` equals `nbr_pin`.
- R8: When `preload_en` is high on a rising edge, the flip-flop loads `preload_val` in any mode, ahead of a normal capture.
- R9: Outside `MC_REG`, and without preload, clock edges leave the flip-flop unchanged. Returning to `MC_REG` shows the old value.
- R10: The encodings `cfg_arch`=2'b00 (either `cfg_cell`) and `cfg_arch`=2'b11 with `cfg_cell`=0 select `MC_OFF`, which gives `pad_oe`=0, `pad_out`=0 and `fb_out`=0.
- R11: `pol_inv`=1 inverts the OR result before the output or the flip-flop. `pol_inv`=0 passes it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock, rising edge |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| pt_in | input | N_TERMS | Product terms from the AND array |
| oe_pin_n | input | 1 | Global output enable, active low (registered mode) |
| pol_inv | input | 1 | 1 inverts the OR result |
| cfg_arch | input | 2 | Device-wide architecture bits |
| cfg_cell | input | 1 | Per-cell architecture bit |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Value loaded by the preload |
| pin_in | input | 1 | Level present on this cell's pin |
| nbr_pin | input | 1 | Level present on the neighbouring cell's pin |
| pad_out | output | 1 | Pin data value |
| pad_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback to the AND array |

## Verification
The combinatorial modes are tried with a table of term patterns. Some patterns set only the top term, which separates the seven-term and eight-term OR widths, and with it the enable-term use of `MC_COMB_IO` from `MC_COMB_OUT`. All-ones patterns are applied in the input and unused encodings, to show that nothing leaks to the pin or the feedback. Distinct levels on `pin_in` and `nbr_pin` show which of the two is returned as feedback. Directed clocked sequences cover the register. They check capture from the top term alone and the preload overriding a conflicting sum. They also check that the register holds across edges in other modes and that the asynchronous clear works in the middle of a run.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;
    typedef enum logic [2:0] {
        MC_OFF      = 3'd0,
        MC_REG      = 3'd1,
        MC_COMB_OUT = 3'd2,
        MC_COMB_IO  = 3'd3,
        MC_INPUT    = 3'd4
    } mc_mode_e;
endpackage

// File: rtl/pal_mc_decode.sv
module pal_mc_decode
    import pal_mc_pkg::*;
(
    input  logic [1:0] cfg_arch,
    input  logic       cfg_cell,
    output mc_mode_e   mode,
    output logic       cap_en,
    output logic       term_oe
);
    always_comb begin
        unique case ({cfg_arch, cfg_cell})
            3'b010:  mode = MC_REG;
            3'b100:  mode = MC_COMB_OUT;
            3'b011:  mode = MC_COMB_IO;
            3'b111:  mode = MC_COMB_IO;
            3'b101:  mode = MC_INPUT;
            default: mode = MC_OFF;
        endcase
    end

    assign cap_en  = (mode == MC_REG);
    assign term_oe = (mode == MC_COMB_IO);
endmodule

// File: rtl/pal_mc_sum.sv
module pal_mc_sum #(
    parameter int N_TERMS = 8
) (
    input  logic [N_TERMS-1:0] pt_in,
    input  logic               term_oe,
    input  logic               pol_inv,
    output logic               sum_pol
);
    localparam int OE_IDX = N_TERMS - 1;

    logic [N_TERMS-1:0] keep;

    // The top term leaves the OR gate when it serves as the pin enable.
    for (genvar i = 0; i < N_TERMS; i++) begin : g_mask
        if (i == OE_IDX) begin : g_oe_term
            assign keep[i] = pt_in[i] & ~term_oe;
        end else begin : g_plain_term
            assign keep[i] = pt_in[i];
        end
    end

    assign sum_pol = (|keep) ^ pol_inv;
endmodule

// File: rtl/pal_mc_reg.sv
module pal_mc_reg (
    input  logic clk,
    input  logic por_n,
    input  logic cap_en,
    input  logic d,
    input  logic preload_en,
    input  logic preload_val,
    output logic q
);
    // Transitions: clear (por_n), load (preload), capture (cap_en), else hold.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          q <= 1'b0;
        else if (preload_en) q <= preload_val;
        else if (cap_en)     q <= d;
    end

    assert_preload_load_R8: assert property (@(posedge clk) disable iff (!por_n)
        preload_en |=> (q == $past(preload_val)));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!por_n)
        (!preload_en && !cap_en) |=> $stable(q));

    assert_capture_R2: assert property (@(posedge clk) disable iff (!por_n)
        (!preload_en && cap_en) |=> (q == $past(d)));
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_mc_pkg::*;
#(
    parameter int N_TERMS = 8
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic [N_TERMS-1:0] pt_in,
    input  logic               oe_pin_n,
    input  logic               pol_inv,
    input  logic [1:0]         cfg_arch,
    input  logic               cfg_cell,
    input  logic               preload_en,
    input  logic               preload_val,
    input  logic               pin_in,
    input  logic               nbr_pin,
    output logic               pad_out,
    output logic               pad_oe,
    output logic               fb_out
);
    localparam int OE_IDX = N_TERMS - 1;

    mc_mode_e mode;
    logic     cap_en;
    logic     term_oe;
    logic     sum_pol;
    logic     q;

    pal_mc_decode u_decode (
        .cfg_arch (cfg_arch),
        .cfg_cell (cfg_cell),
        .mode     (mode),
        .cap_en   (cap_en),
        .term_oe  (term_oe)
    );

    pal_mc_sum #(.N_TERMS(N_TERMS)) u_sum (
        .pt_in   (pt_in),
        .term_oe (term_oe),
        .pol_inv (pol_inv),
        .sum_pol (sum_pol)
    );

    pal_mc_reg u_reg (
        .clk         (clk),
        .por_n       (por_n),
        .cap_en      (cap_en),
        .d           (sum_pol),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .q           (q)
    );

    always_comb begin
        unique case (mode)
            MC_REG: begin
                pad_out = q;
                pad_oe  = ~oe_pin_n;
                fb_out  = ~q;
            end
            MC_COMB_OUT: begin
                pad_out = sum_pol;
                pad_oe  = 1'b1;
                fb_out  = 1'b0;
            end
            MC_COMB_IO: begin
                pad_out = sum_pol;
                pad_oe  = pt_in[OE_IDX];
                fb_out  = pin_in;
            end
            MC_INPUT: begin
                pad_out = 1'b0;
                pad_oe  = 1'b0;
                fb_out  = nbr_pin;
            end
            default: begin
                pad_out = 1'b0;
                pad_oe  = 1'b0;
                fb_out  = 1'b0;
            end
        endcase
    end

    assert_reg_fb_R2: assert property (@(posedge clk) disable iff (!por_n)
        (mode == MC_REG) |-> (fb_out != pad_out));

    assert_reg_oe_R3: assert property (@(posedge clk) disable iff (!por_n)
        (mode == MC_REG) |-> (pad_oe == !oe_pin_n));

    assert_io_enable_R6: assert property (@(posedge clk) disable iff (!por_n)
        (mode == MC_COMB_IO) |-> (pad_oe == pt_in[OE_IDX] && fb_out == pin_in));

    assert_input_quiet_R7: assert property (@(posedge clk) disable iff (!por_n)
        (mode == MC_INPUT) |-> (!pad_oe && fb_out == nbr_pin));

    assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!por_n)
        (mode == MC_OFF) |-> (!pad_oe && !pad_out && !fb_out));
endmodule

// File: tb/sim_pal_macrocell.sv
module sim_pal_macrocell;
    logic       clk = 1'b0;
    logic       por_n;
    logic [7:0] pt_in;
    logic       oe_pin_n, pol_inv, cfg_cell, preload_en, preload_val, pin_in, nbr_pin;
    logic [1:0] cfg_arch;
    logic       pad_out, pad_oe, fb_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pal_macrocell #(.N_TERMS(8)) u0 (
        .clk(clk), .por_n(por_n), .pt_in(pt_in), .oe_pin_n(oe_pin_n),
        .pol_inv(pol_inv), .cfg_arch(cfg_arch), .cfg_cell(cfg_cell),
        .preload_en(preload_en), .preload_val(preload_val),
        .pin_in(pin_in), .nbr_pin(nbr_pin),
        .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
    );

    // {req[3:0], arch[1:0], cell, pt[7:0], pol, oe_n, pin, nbr, exp_out, exp_oe, exp_fb}
    localparam logic [21:0] VEC [0:11] = '{
        {4'd4,  2'b10, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 empty sum
        {4'd4,  2'b10, 1'b0, 8'h80, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R4 top term counts
        {4'd11, 2'b10, 1'b0, 8'h04, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R11 inverted
        {4'd5,  2'b01, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 top term excluded
        {4'd6,  2'b01, 1'b1, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R6 pin fed back
        {4'd5,  2'b11, 1'b1, 8'hC0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R5 second encoding
        {4'd11, 2'b11, 1'b1, 8'h40, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R11 in I/O mode
        {4'd7,  2'b10, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 neighbour high
        {4'd7,  2'b10, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 neighbour low
        {4'd10, 2'b00, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R10 000
        {4'd10, 2'b00, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R10 001
        {4'd10, 2'b11, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}  // R10 110
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic set_reg_mode();
        cfg_arch = 2'b01;
        cfg_cell = 1'b0;
    endtask

    task automatic edge_then_settle();
        @(posedge clk);
        #2;
    endtask

    initial begin
        por_n = 1'b0; pt_in = '0; oe_pin_n = 1'b0; pol_inv = 1'b0;
        preload_en = 1'b0; preload_val = 1'b0; pin_in = 1'b0; nbr_pin = 1'b0;
        set_reg_mode();
        #5;
        chk("R1 reset pad_out", pad_out, 1'b0);
        chk("R1 reset fb_out", fb_out, 1'b1);
        chk("R3 reset pad_oe", pad_oe, 1'b1);
        @(negedge clk); @(negedge clk);
        por_n = 1'b1;

        // Table of combinatorial modes
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            cfg_arch = VEC[i][17:16]; cfg_cell = VEC[i][15];
            pt_in = VEC[i][14:7]; pol_inv = VEC[i][6]; oe_pin_n = VEC[i][5];
            pin_in = VEC[i][4]; nbr_pin = VEC[i][3];
            #1;
            n_run += 3;
            if (pad_out !== VEC[i][2] || pad_oe !== VEC[i][1] || fb_out !== VEC[i][0]) begin
                n_fail++;
                $display("FAIL R%0d vec %0d: actual out/oe/fb %b%b%b expected %b%b%b",
                         VEC[i][21:18], i, pad_out, pad_oe, fb_out,
                         VEC[i][2], VEC[i][1], VEC[i][0]);
            end
        end

        // R2: capture from the top term alone
        @(negedge clk); set_reg_mode(); pt_in = 8'h80; pol_inv = 1'b0; oe_pin_n = 1'b0;
        edge_then_settle();
        chk("R2 capture top term", pad_out, 1'b1);
        chk("R2 inverted feedback", fb_out, 1'b0);
        // R3: enable follows the global pin, not the top term
        @(negedge clk); oe_pin_n = 1'b1; #1;
        chk("R3 global oe off", pad_oe, 1'b0);
        // R11: polarity applied before the register
        @(negedge clk); pt_in = 8'h01; pol_inv = 1'b1; oe_pin_n = 1'b0;
        edge_then_settle();
        chk("R11 registered invert", pad_out, 1'b0);
        // R8: preload beats a conflicting capture
        @(negedge clk); pt_in = 8'h00; pol_inv = 1'b0; preload_en = 1'b1; preload_val = 1'b1;
        edge_then_settle();
        chk("R8 preload one", pad_out, 1'b1);
        @(negedge clk); pt_in = 8'hFF; preload_val = 1'b0;
        edge_then_settle();
        chk("R8 preload zero", pad_out, 1'b0);
        // R9: edges in another mode leave the register alone
        @(negedge clk); preload_en = 1'b0; cfg_arch = 2'b10; cfg_cell = 1'b0; pt_in = 8'hFF;
        edge_then_settle(); edge_then_settle();
        @(negedge clk); set_reg_mode(); #1;
        chk("R9 held across edges", pad_out, 1'b0);
        // R8: preload also works outside registered mode
        @(negedge clk); cfg_arch = 2'b01; cfg_cell = 1'b1; preload_en = 1'b1; preload_val = 1'b1;
        edge_then_settle();
        @(negedge clk); preload_en = 1'b0; set_reg_mode(); #1;
        chk("R8 preload in io mode", pad_out, 1'b1);
        // R1: asynchronous clear in the middle of a run
        #3; por_n = 1'b0; #1;
        chk("R1 async clear", pad_out, 1'b0);
        chk("R1 async clear fb", fb_out, 1'b1);
        @(negedge clk); por_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule